// File: doc/BRIEF.md
# Page Translation Cache

This block holds recently used logical-to-physical page translations so that a memory management unit can skip its table walk. It is fully associative with 22 entries and 256-byte pages. Each entry is tagged by the upper 24 bits of the logical address and by a 3-bit function code that comes from the privilege level of the access. A lookup is combinational. The physical address it returns is the stored physical page joined to the untranslated low byte of the logical address.

New entries come from two places. One is the table walker's result port. The other is a preload command, which installs a translation for a given logical address. An insert whose page and privilege are already present is dropped. Otherwise the new entry takes the lowest-numbered empty slot. When no slot is empty, it replaces the slot chosen by a rotating victim pointer. A small command decoder turns the MMU's command stream into insert and flush strobes. Flushing empties every slot and returns the victim pointer to slot 0.

Top module: `xlate_cache`

## Requirements
- R1: After reset is asserted (rstN low, asynchronous), every lookup misses (lookHit = 0, lookPhys = 0) until something is inserted.
- R2: A lookup hits only when a valid entry holds both the logical page (address bits 31:8) and the function code of the access. On a hit, lookPhys = {stored physical page, lookLogical[7:0]}. On a miss, lookPhys = 0.
- R3: The function code is 5 when the supervisor flag is 1 and 1 when it is 0. An entry inserted at one privilege level therefore misses a lookup of the same page at the other level.
- R4: An insert whose page and function code match a valid entry changes nothing. The original physical page is kept and the victim pointer does not move.
- R5: An insert that is not a duplicate, while an empty slot exists, fills the lowest-numbered empty slot and leaves the victim pointer unchanged.
- R6: An insert that is not a duplicate, while all 22 slots are full, overwrites the slot at the victim pointer. The pointer then advances by one and wraps from 21 to 0. After reset and after a flush the pointer is 0.
- R7: A flush empties every slot and sets the victim pointer to 0. It takes effect at the next clock edge.
- R8: cmdOp encodes 0 idle, 1 preload, 2 flush-entries, 3 flush-root, 4 write control, 5 write supervisor root, 6 write CPU root, 7 write other register. A valid command with code 2 or 3 flushes. Codes 4 to 6 flush only when cmdHold (the flush-disable bit) is 0. Codes 0, 1 and 7 never flush.
- R9: A preload (code 1) inserts cmdLogical at privilege cmdSuper. The physical address is cmdXlatePhys when xlateOn is 1 and cmdLogical when it is 0. If a preload and a walker insert (insValid) arrive in the same cycle, the preload is taken and the walker insert is dropped.
- R10: When a flush and an insert arrive in the same cycle, the flush wins and the cache ends empty.
- R11: Reset asserted mid-operation empties the cache like a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; empties the cache |
| lookLogical | input | 32 | Logical address to translate |
| lookSuper | input | 1 | Privilege of the lookup (1 = supervisor) |
| lookHit | output | 1 | Translation present |
| lookPhys | output | 32 | Translated address on a hit, 0 on a miss |
| insValid | input | 1 | Walker insert strobe |
| insLogical | input | 32 | Walker insert logical address |
| insPhys | input | 32 | Walker insert physical address |
| insSuper | input | 1 | Walker insert privilege |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code (see R8) |
| cmdHold | input | 1 | Flush-disable bit for register writes |
| cmdLogical | input | 32 | Preload logical address |
| cmdSuper | input | 1 | Preload privilege |
| xlateOn | input | 1 | Translation enabled |
| cmdXlatePhys | input | 32 | Translated address used by a preload when translation is on |

## Verification
The assertion that at most one entry matches a lookup assumes that entries are only ever added through the insert path. That path refuses duplicates, and the stimulus has no other way to load the store. The assertions also assume that every input is a known value at each clock edge. The bench drives all inputs from reset onward and changes them only on the falling edge. Walker inserts and preloads draw their pages from a pool of 48 pages at both privilege levels, so duplicates, evictions and victim-pointer wraps all occur. Flush commands are kept rare so that the cache spends most of its time full.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_PRELOAD    = 3'd1,
    OP_FLUSH_ALL  = 3'd2,
    OP_FLUSH_ROOT = 3'd3,
    OP_WR_CTRL    = 3'd4,
    OP_WR_SUPROOT = 3'd5,
    OP_WR_CPUROOT = 3'd6,
    OP_WR_OTHER   = 3'd7
  } xlcOp_t;

  // strobes from the command decoder to the entry store
  typedef struct packed {
    logic              flush;
    logic              ins;
    logic [ADDR_W-1:0] insLog;
    logic [ADDR_W-1:0] insPhys;
    logic              insSuper;
  } xlcStrobe_t;

  function automatic logic [2:0] fcFor(input logic isSuper);
    return isSuper ? 3'd5 : 3'd1;
  endfunction
endpackage

// File: rtl/xlc_ctrl.sv
module xlc_ctrl
  import xlc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insLogical,
  input  logic [ADDR_W-1:0] insPhys,
  input  logic              insSuper,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic              cmdHold,
  input  logic [ADDR_W-1:0] cmdLogical,
  input  logic              cmdSuper,
  input  logic              xlateOn,
  input  logic [ADDR_W-1:0] cmdXlatePhys,
  output xlcStrobe_t        strobe
);
  xlcOp_t op;
  logic   rootWrite;
  logic   preload;

  always_comb begin
    op        = xlcOp_t'(cmdOp);
    rootWrite = (op == OP_WR_CTRL) || (op == OP_WR_SUPROOT) || (op == OP_WR_CPUROOT);
    preload   = cmdValid && (op == OP_PRELOAD);

    strobe.flush = cmdValid &&
                   ((op == OP_FLUSH_ALL) || (op == OP_FLUSH_ROOT) || (rootWrite && !cmdHold));
    strobe.ins   = preload || insValid;
    if (preload) begin
      strobe.insLog   = cmdLogical;
      strobe.insPhys  = xlateOn ? cmdXlatePhys : cmdLogical;
      strobe.insSuper = cmdSuper;
    end else begin
      strobe.insLog   = insLogical;
      strobe.insPhys  = insPhys;
      strobe.insSuper = insSuper;
    end
  end

  // R8: a register write with the flush-disable bit set must not flush
  a_r8_hold_blocks_flush: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdHold && cmdOp >= 3'd4 && cmdOp <= 3'd6) |-> !strobe.flush);

  // R8: idle, preload and other-register writes never flush
  a_r8_quiet_ops: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 3'd0 || cmdOp == 3'd1 || cmdOp == 3'd7)) |-> !strobe.flush);

  // R9: untranslated preload installs identity mapping
  a_r9_preload_identity: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd1 && !xlateOn) |-> (strobe.ins && strobe.insPhys == cmdLogical));
endmodule

// File: rtl/xlc_store.sv
module xlc_store
  import xlc_pkg::*;
#(
  parameter int ENTRIES = 22,
  parameter int OFF_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlcStrobe_t        strobe,
  input  logic [ADDR_W-1:0] lookLogical,
  input  logic              lookSuper,
  output logic              lookHit,
  output logic [ADDR_W-1:0] lookPhys
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid;
  logic [PAGE_W-1:0]  tagArr  [ENTRIES];
  logic [2:0]         fcArr   [ENTRIES];
  logic [PAGE_W-1:0]  pageArr [ENTRIES];
  logic [IDX_W-1:0]   rrPtr;

  logic [PAGE_W-1:0]  lookPage, insPage;
  logic [2:0]         lookFc, insFc;
  logic [ENTRIES-1:0] lookMatch, dupMatch;
  logic [IDX_W-1:0]   hitIdx, freeIdx, victim;
  logic               hasFree, isDup, writeEn;

  assign lookPage = lookLogical[ADDR_W-1:OFF_W];
  assign lookFc   = fcFor(lookSuper);
  assign insPage  = strobe.insLog[ADDR_W-1:OFF_W];
  assign insFc    = fcFor(strobe.insSuper);

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lookMatch[g] = valid[g] && (tagArr[g] == lookPage) && (fcArr[g] == lookFc);
    assign dupMatch[g]  = valid[g] && (tagArr[g] == insPage)  && (fcArr[g] == insFc);
  end

  // lowest-index pick for hit and for free slot
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lookMatch[i]) hitIdx  = IDX_W'(i);
      if (!valid[i])    freeIdx = IDX_W'(i);
    end
  end

  assign hasFree = ~&valid;
  assign isDup   = |dupMatch;
  assign victim  = hasFree ? freeIdx : rrPtr;
  assign writeEn = strobe.ins && !strobe.flush && !isDup;

  assign lookHit  = |lookMatch;
  assign lookPhys = lookHit ? {pageArr[hitIdx], lookLogical[OFF_W-1:0]} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= '0;
      rrPtr <= '0;
    end else if (strobe.flush) begin
      valid <= '0;
      rrPtr <= '0;
    end else if (writeEn) begin
      valid[victim] <= 1'b1;
      if (!hasFree) rrPtr <= (rrPtr == LAST) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (writeEn) begin
      tagArr[victim]  <= insPage;
      fcArr[victim]   <= insFc;
      pageArr[victim] <= strobe.insPhys[ADDR_W-1:OFF_W];
    end
  end

  // R2: no two entries ever answer the same lookup
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rstN) $onehot0(lookMatch));

  // R7: flush leaves the store empty with the pointer home
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (valid == '0 && rrPtr == '0));

  // R10: flush beats a same-cycle insert
  a_r10_flush_over_insert: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flush && strobe.ins) |=> (valid == '0));

  // R4: duplicate insert leaves occupancy and pointer unchanged
  a_r4_dup_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ins && !strobe.flush && isDup) |=> ($stable(valid) && $stable(rrPtr)));

  // R5: fill of a free slot adds exactly one entry, pointer still
  a_r5_fill_free: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ins && !strobe.flush && !isDup && hasFree) |=>
      ($countones(valid) == $countones($past(valid)) + 1 && $stable(rrPtr)));

  // R6: eviction keeps the store full and moves the pointer
  a_r6_evict_moves: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ins && !strobe.flush && !isDup && !hasFree) |=> ((&valid) && rrPtr != $past(rrPtr)));

  // R6: pointer stays inside the entry range
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rstN) rrPtr <= LAST);
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlc_pkg::*;
#(
  parameter int ENTRIES = 22,
  parameter int OFF_W   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] lookLogical,
  input  logic        lookSuper,
  output logic        lookHit,
  output logic [31:0] lookPhys,
  input  logic        insValid,
  input  logic [31:0] insLogical,
  input  logic [31:0] insPhys,
  input  logic        insSuper,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic        cmdHold,
  input  logic [31:0] cmdLogical,
  input  logic        cmdSuper,
  input  logic        xlateOn,
  input  logic [31:0] cmdXlatePhys
);
  xlcStrobe_t strobe;

  xlc_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insLogical(insLogical), .insPhys(insPhys), .insSuper(insSuper),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdHold(cmdHold), .cmdLogical(cmdLogical),
    .cmdSuper(cmdSuper), .xlateOn(xlateOn), .cmdXlatePhys(cmdXlatePhys),
    .strobe(strobe)
  );

  xlc_store #(.ENTRIES(ENTRIES), .OFF_W(OFF_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookLogical(lookLogical), .lookSuper(lookSuper),
    .lookHit(lookHit), .lookPhys(lookPhys)
  );
endmodule

// File: tb/tb_xlate_cache.sv
`timescale 1ns/1ps
module tb_xlate_cache;
  localparam int N = 22;
  localparam int POOL = 48;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic [31:0] lookLogical;
  logic        lookSuper;
  logic        lookHit;
  logic [31:0] lookPhys;
  logic        insValid;
  logic [31:0] insLogical, insPhys;
  logic        insSuper;
  logic        cmdValid;
  logic [2:0]  cmdOp;
  logic        cmdHold;
  logic [31:0] cmdLogical;
  logic        cmdSuper;
  logic        xlateOn;
  logic [31:0] cmdXlatePhys;

  xlate_cache dut (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference contents
  bit          mV [N];
  logic [23:0] mT [N];
  logic [2:0]  mF [N];
  logic [23:0] mP [N];
  int          mRr;

  function automatic logic [2:0] fcOf(input logic s);
    return s ? 3'd5 : 3'd1;
  endfunction

  function automatic logic [23:0] pageOf(input int k);
    return 24'(k * 24'h010203) ^ 24'hA5C35A;
  endfunction

  function automatic logic [23:0] physOf(input int k);
    return 24'(k * 24'h0F0E01) + 24'h300000;
  endfunction

  function automatic void mFlush();
    for (int i = 0; i < N; i++) mV[i] = 0;
    mRr = 0;
  endfunction

  function automatic void mInsert(input logic [31:0] l, input logic [31:0] p, input logic s);
    int slot;
    slot = -1;
    for (int i = 0; i < N; i++)
      if (mV[i] && mT[i] == l[31:8] && mF[i] == fcOf(s)) return;
    for (int i = 0; i < N; i++)
      if (!mV[i] && slot < 0) slot = i;
    if (slot < 0) begin
      slot = mRr;
      mRr = (mRr == N - 1) ? 0 : mRr + 1;
    end
    mV[slot] = 1; mT[slot] = l[31:8]; mF[slot] = fcOf(s); mP[slot] = p[31:8];
  endfunction

  function automatic void mEdge();
    logic fl, pre;
    fl  = cmdValid && (cmdOp == 3'd2 || cmdOp == 3'd3 ||
                       (cmdOp >= 3'd4 && cmdOp <= 3'd6 && !cmdHold));
    pre = cmdValid && cmdOp == 3'd1;
    if (fl) mFlush();
    else if (pre) mInsert(cmdLogical, xlateOn ? cmdXlatePhys : cmdLogical, cmdSuper);
    else if (insValid) mInsert(insLogical, insPhys, insSuper);
  endfunction

  task automatic step();
    @(posedge clk);
    mEdge();
    @(negedge clk);
    insValid = 0;
    cmdValid = 0;
  endtask

  task automatic check(input logic [31:0] a, input logic s, input string req);
    logic        eHit;
    logic [31:0] ePhys;
    lookLogical = a;
    lookSuper   = s;
    #1;
    eHit = 0; ePhys = '0;
    for (int i = 0; i < N; i++)
      if (mV[i] && mT[i] == a[31:8] && mF[i] == fcOf(s)) begin
        eHit = 1; ePhys = {mP[i], a[7:0]};
      end
    checks++;
    if (lookHit !== eHit || lookPhys !== ePhys) begin
      errors++;
      $display("FAIL %s addr=%h sup=%0b: hit=%0b phys=%h expected hit=%0b phys=%h",
               req, a, s, lookHit, lookPhys, eHit, ePhys);
    end
  endtask

  task automatic checkAll(input string req);
    for (int k = 0; k < POOL; k++) begin
      check({pageOf(k), 8'($urandom)}, 1'b0, req);
      check({pageOf(k), 8'($urandom)}, 1'b1, req);
    end
  endtask

  task automatic walkIns(input int k, input logic s, input logic [23:0] ph);
    @(negedge clk);
    insValid = 1; insLogical = {pageOf(k), 8'($urandom)}; insPhys = {ph, 8'($urandom)}; insSuper = s;
    step();
  endtask

  task automatic command(input logic [2:0] op, input logic hold);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdHold = hold;
    step();
  endtask

  task automatic preload(input int k, input logic s, input logic xon, input logic [23:0] xph);
    @(negedge clk);
    cmdValid = 1; cmdOp = 3'd1; cmdHold = 0; cmdSuper = s; xlateOn = xon;
    cmdLogical = {pageOf(k), 8'h11}; cmdXlatePhys = {xph, 8'h22};
    step();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    mFlush();
    #2;
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; lookLogical = '0; lookSuper = 0;
    insValid = 0; insLogical = '0; insPhys = '0; insSuper = 0;
    cmdValid = 0; cmdOp = '0; cmdHold = 0; cmdLogical = '0; cmdSuper = 0;
    xlateOn = 0; cmdXlatePhys = '0;
    mFlush();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: empty after reset
    check({pageOf(0), 8'h00}, 1'b0, "R1 reset empty");
    check(32'h0000_0000, 1'b1, "R1 reset empty");

    // R5 / R2: fill all slots in order
    for (int k = 0; k < N; k++) walkIns(k, 1'b0, physOf(k));
    checkAll("R5 R2 fill");
    // R3: other privilege misses
    check({pageOf(5), 8'h7E}, 1'b1, "R3 privilege mismatch");

    // R4: duplicate with new physical page is dropped
    walkIns(3, 1'b0, 24'hDEAD01);
    check({pageOf(3), 8'h44}, 1'b0, "R4 duplicate dropped");

    // R6: eviction in pointer order and wrap
    for (int k = N; k < 2 * N + 2; k++) begin
      walkIns(k, 1'b0, physOf(k));
      check({pageOf(k), 8'h01}, 1'b0, "R6 newest present");
      check({pageOf(k - N), 8'h02}, 1'b0, "R6 victim order");
    end
    checkAll("R6 after wrap");

    // R8: hold bit and other writes keep contents
    command(3'd4, 1'b1); checkAll("R8 hold on ctrl write");
    command(3'd5, 1'b1); command(3'd6, 1'b1); command(3'd7, 1'b0); command(3'd0, 1'b0);
    checkAll("R8 non-flushing ops");
    command(3'd6, 1'b0); checkAll("R8 cpu root write flush");

    // R9: preload identity and translated
    preload(7, 1'b1, 1'b0, 24'h0);
    check({pageOf(7), 8'h9A}, 1'b1, "R9 preload identity");
    preload(8, 1'b0, 1'b1, 24'h55AA33);
    check({pageOf(8), 8'h9B}, 1'b0, "R9 preload translated");
    // R9: preload beats walker insert in the same cycle
    @(negedge clk);
    cmdValid = 1; cmdOp = 3'd1; cmdHold = 0; cmdSuper = 0; xlateOn = 0;
    cmdLogical = {pageOf(9), 8'h00};
    insValid = 1; insLogical = {pageOf(10), 8'h00}; insPhys = 32'h1234_5600; insSuper = 0;
    step();
    check({pageOf(9), 8'h03}, 1'b0, "R9 preload priority");
    check({pageOf(10), 8'h04}, 1'b0, "R9 walker dropped");

    command(3'd2, 1'b0); checkAll("R7 flush entries");
    for (int k = 0; k < N + 3; k++) walkIns(k, k[0], physOf(k));
    command(3'd3, 1'b0); checkAll("R7 flush root");
    // R7: pointer home after flush, so slot 0 is evicted first
    for (int k = 0; k < N + 1; k++) walkIns(k + 5, 1'b1, physOf(k));
    checkAll("R7 pointer reset");

    // R10: flush and insert together
    @(negedge clk);
    cmdValid = 1; cmdOp = 3'd4; cmdHold = 0;
    insValid = 1; insLogical = {pageOf(40), 8'h00}; insPhys = 32'h7777_7700; insSuper = 0;
    step();
    check({pageOf(40), 8'h05}, 1'b0, "R10 flush wins");
    checkAll("R10 empty");

    // R11: reset mid-operation
    for (int k = 0; k < 10; k++) walkIns(k, 1'b0, physOf(k));
    doReset();
    checkAll("R11 reset flush");

    // constrained random
    for (int it = 0; it < 3000; it++) begin
      int r, k;
      r = int'($urandom_range(0, 99));
      k = int'($urandom_range(0, POOL - 1));
      @(negedge clk);
      if (r < 70) begin
        insValid = 1; insLogical = {pageOf(k), 8'($urandom)};
        insPhys = $urandom; insSuper = 1'($urandom);
      end
      if (r >= 60 && r < 80) begin
        cmdValid = 1; cmdOp = 3'd1; cmdSuper = 1'($urandom); xlateOn = 1'($urandom);
        cmdLogical = {pageOf(k ^ 5), 8'($urandom)}; cmdXlatePhys = $urandom; cmdHold = 0;
      end else if (r >= 97) begin
        cmdValid = 1; cmdOp = 3'($urandom); cmdHold = 1'($urandom);
        cmdLogical = $urandom; cmdXlatePhys = $urandom;
      end
      step();
      check({pageOf(int'($urandom_range(0, POOL - 1))), 8'($urandom)}, 1'($urandom), "R2 R6 random");
      check({pageOf(k), 8'($urandom)}, 1'($urandom), "R4 R5 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule